// File: doc/BRIEF.md
# Match-Controlled Timer Counter

This block is a free-running timer with a programmable prescaler and four compare channels. A prescale counter counts clock cycles. Each time it reaches the programmed prescale limit it returns to zero and the timer count advances by one. Each channel holds a compare value. A per-channel action field chooses whether an equality between that value and the timer count raises a sticky interrupt flag, returns the count to zero, halts the timer, or any mix of the three.

Each compare value has a companion staging register. When staging is enabled for a channel, its compare value is refreshed from the staging register whenever the count is forced back to zero. This lets software retune the period safely while the timer runs. All registers are reached through a plain word-addressed write strobe and a combinational read-data bus.

A compare event occurs only while the timer runs. It fires on the prescaler's wrap cycle while the timer count equals the compare value. As a result, a channel that resets on match with value M gives a period of M+1 count steps.

Top module: `match_timer`

## Requirements
- R1: After reset the control register, prescale counter, timer count, action register and interrupt flags all read 0, and `irq` is low.
- R2: The control register is at address 0x0. While its enable bit (bit 0) is 1 and its clear bit (bit 1) is 0, the prescale counter (address 0x3) advances once per clock. When it equals the prescale limit (address 0x2), it wraps to 0 and the timer count (address 0x4) advances by one. While the enable bit is 0, neither counter changes.
- R3: While the clear bit of the control register is 1, the timer count and the prescale counter are held at 0 on every clock.
- R4: The action register is at address 0x1. Channel n uses bit 3n to raise an interrupt, bit 3n+1 to reset the count and bit 3n+2 to stop. A reset-on-match event returns the timer count to 0 in place of advancing it.
- R5: A match on a channel whose interrupt bit is set sets bit n of the flag register (address 0x5) and the `irq_flags` output. The flag stays set until 1 is written to that bit. Writing 0 to a bit leaves it unchanged. `irq` is the OR of the four flags.
- R6: A stop-on-match event clears the enable bit. The timer count stays at the matched value and the prescale counter reads 0.
- R7: When several channels match on the same cycle, all of their selected actions take effect together.
- R8: When bit 24+n of the action register is set, compare register n (address 0x8+n) is loaded from staging register n (address 0xC+n) whenever a reset-on-match event returns the count to zero.
- R9: With bit 24+n set, a cycle in which the control clear bit is 1 also loads compare register n from staging register n.
- R10: Bits 12 to 23 and 28 to 31 of the action register ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Word address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr` (combinational) |
| irq_flags | output | 4 | Sticky per-channel interrupt flags |
| irq | output | 1 | OR of all interrupt flags |

## Verification
On every cycle, the assertions check the following:
- the count holds while the clear bit is set;
- the count is frozen while the timer is disabled;
- enable drops and the count holds after a stop;
- `irq` follows any interrupt match;
- the compare register is refreshed from staging whenever the count returns to zero with staging enabled.

The period that results from the prescale limit and compare value can only be shown by the bench's randomized runs and directed scenarios. The same holds for the combined effect of simultaneous matches, write-one-to-clear flags and masking of the reserved bits.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [3:0]       irq_flags,
  output logic             irq
);

  localparam int NCH = 4;
  localparam int CFG_BITS = 28;
  localparam logic [CFG_BITS-1:0] CFG_MASK = 28'h F000FFF;
  localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h1, A_PRE = 4'h2, A_PCNT = 4'h3,
                         A_TCNT = 4'h4, A_FLAG = 4'h5;

  logic                ctrl_en, ctrl_clr;
  logic [CFG_BITS-1:0] cfg;
  logic [WIDTH-1:0]    pre, pcnt, tc;
  logic [WIDTH-1:0]    mr  [NCH];
  logic [WIDTH-1:0]    shd [NCH];
  logic [NCH-1:0]      flags;

  logic           running, tick, rst_hit, stop_hit, tc_zero;
  logic [NCH-1:0] hit, on_irq, on_rst, on_stop, on_reload, irq_hit;

  assign running = ctrl_en & ~ctrl_clr;
  assign tick    = running & (pcnt >= pre);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign on_irq[n]    = cfg[3*n];
    assign on_rst[n]    = cfg[3*n+1];
    assign on_stop[n]   = cfg[3*n+2];
    assign on_reload[n] = cfg[24+n];
    assign hit[n]       = tick & (tc == mr[n]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mr[n]  <= '0;
        shd[n] <= '0;
      end else begin
        if (we && addr == 4'(8 + n)) mr[n] <= wdata;
        if (tc_zero && on_reload[n]) mr[n] <= shd[n];
        if (we && addr == 4'(12 + n)) shd[n] <= wdata;
      end
    end

    // R8 R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_zero && on_reload[n]) |=> mr[n] == $past(shd[n]));
  end

  assign irq_hit  = hit & on_irq;
  assign rst_hit  = |(hit & on_rst);
  assign stop_hit = |(hit & on_stop);
  assign tc_zero  = ctrl_clr | rst_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_clr <= 1'b0;
      cfg      <= '0;
      pre      <= '0;
    end else begin
      if (we && addr == A_CTRL) begin
        ctrl_en  <= wdata[0];
        ctrl_clr <= wdata[1];
      end
      if (stop_hit) ctrl_en <= 1'b0;
      if (we && addr == A_CFG) cfg <= wdata[CFG_BITS-1:0] & CFG_MASK;
      if (we && addr == A_PRE) pre <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      tc   <= '0;
    end else if (ctrl_clr) begin
      pcnt <= '0;
      tc   <= '0;
    end else if (running) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (rst_hit)                tc <= '0;
      else if (tick && !stop_hit) tc <= tc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else begin
      if (we && addr == A_FLAG) flags <= (flags & ~wdata[NCH-1:0]) | irq_hit;
      else                      flags <= flags | irq_hit;
    end
  end

  assign irq_flags = flags;
  assign irq       = |flags;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = {{(WIDTH-2){1'b0}}, ctrl_clr, ctrl_en};
      A_CFG:  rdata = {{(WIDTH-CFG_BITS){1'b0}}, cfg};
      A_PRE:  rdata = pre;
      A_PCNT: rdata = pcnt;
      A_TCNT: rdata = tc;
      A_FLAG: rdata = {{(WIDTH-NCH){1'b0}}, flags};
      4'h8, 4'h9, 4'hA, 4'hB: rdata = mr[addr[1:0]];
      4'hC, 4'hD, 4'hE, 4'hF: rdata = shd[addr[1:0]];
      default: rdata = '0;
    endcase
  end

  // R3
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |=> (tc == '0) && (pcnt == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !ctrl_clr) |=> $stable(tc) && $stable(pcnt));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !rst_hit) |=> !ctrl_en && tc == $past(tc));

  // R5
  flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_hit) |=> irq);

endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
  localparam int W = 32;
  logic         clk = 0, rst_n = 0, we = 0;
  logic [3:0]   addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic [3:0]   irq_flags;
  logic         irq;
  int n_chk = 0, n_bad = 0;

  match_timer #(.WIDTH(W)) uut (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_flags(irq_flags), .irq(irq));

  always #4 clk = ~clk;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [W-1:0] exp);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic run(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic restart();
    wr(4'h0, 2);
    wr(4'h0, 0);
    wr(4'h5, 32'hF);
  endtask

  function automatic int exp_tc(int k, int pr, int m);
    return (k / (pr + 1)) % (m + 1);
  endfunction
  function automatic int exp_pc(int k, int pr);
    return k % (pr + 1);
  endfunction
  function automatic int exp_flag(int k, int pr, int m);
    return (k >= (m + 1) * (pr + 1)) ? 1 : 0;
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(20250611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1
    rd_chk("R1 ctrl", 4'h0, 0);
    rd_chk("R1 tc", 4'h4, 0);
    rd_chk("R1 pc", 4'h3, 0);
    rd_chk("R1 cfg", 4'h1, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 prescale 2, ten counts
    wr(4'h2, 2);
    wr(4'h0, 1);
    run(10);
    rd_chk("R2 tc", 4'h4, 3);
    rd_chk("R2 pc", 4'h3, 1);
    wr(4'h0, 0);
    run(5);
    rd_chk("R2 hold tc", 4'h4, 3);

    // R3 clear held with enable
    wr(4'h0, 3);
    run(4);
    rd_chk("R3 tc", 4'h4, 0);
    rd_chk("R3 pc", 4'h3, 0);

    // R4 R5 reset + interrupt on channel 0
    restart();
    wr(4'h2, 0);
    wr(4'h8, 4);
    wr(4'h1, 32'h3);
    wr(4'h0, 1);
    run(4);
    rd_chk("R4 tc before", 4'h4, 4);
    check("R5 flag before", {28'b0, irq_flags}, 0);
    run(1);
    rd_chk("R4 tc wrapped", 4'h4, 0);
    check("R5 flag set", {28'b0, irq_flags}, 1);
    check("R5 irq", {31'b0, irq}, 1);
    wr(4'h0, 0);
    wr(4'h5, 0);
    rd_chk("R5 write0 keeps", 4'h5, 1);
    wr(4'h5, 1);
    rd_chk("R5 w1c", 4'h5, 0);
    check("R5 irq low", {31'b0, irq}, 0);

    // R6 stop on channel 1 with prescale 1
    restart();
    wr(4'h2, 1);
    wr(4'h9, 3);
    wr(4'h1, 32'h28);
    wr(4'h0, 1);
    run(20);
    rd_chk("R6 tc", 4'h4, 3);
    rd_chk("R6 pc", 4'h3, 0);
    rd_chk("R6 ctrl", 4'h0, 0);
    rd_chk("R6 flag", 4'h5, 2);

    // R7 simultaneous: ch2 reset+irq, ch3 stop at 6, ch0 irq at 2
    restart();
    wr(4'h2, 0);
    wr(4'h8, 2);
    wr(4'hA, 6);
    wr(4'hB, 6);
    wr(4'h1, 32'h8C1);
    wr(4'h0, 1);
    run(12);
    rd_chk("R7 tc", 4'h4, 0);
    rd_chk("R7 ctrl", 4'h0, 0);
    rd_chk("R7 flags", 4'h5, 32'h5);

    // R8 reload on match
    restart();
    wr(4'h1, 0);
    wr(4'h8, 3);
    wr(4'hC, 6);
    wr(4'h1, 32'h0100_0002);
    wr(4'h0, 1);
    run(9);
    rd_chk("R8 tc", 4'h4, 5);
    rd_chk("R8 match0", 4'h8, 6);
    wr(4'h0, 0);

    // R9 reload on software clear
    wr(4'hC, 9);
    rd_chk("R9 before", 4'h8, 6);
    wr(4'h0, 2);
    wr(4'h0, 0);
    rd_chk("R9 match0", 4'h8, 9);

    // R10 reserved bits
    wr(4'h1, 32'hFFFF_FFFF);
    rd_chk("R10 cfg", 4'h1, 32'h0F00_0FFF);

    // R2 R4 R5 randomized periods
    for (int i = 0; i < 24; i++) begin
      int pr = $urandom % 4;
      int m  = 1 + $urandom % 12;
      int k  = 1 + $urandom % 80;
      wr(4'h1, 0);
      restart();
      wr(4'h2, pr);
      wr(4'h8, m);
      wr(4'h1, 32'h3);
      wr(4'h0, 1);
      run(k);
      rd_chk("R4 rand tc", 4'h4, exp_tc(k, pr, m));
      rd_chk("R2 rand pc", 4'h3, exp_pc(k, pr));
      check("R5 rand flag", {31'b0, irq_flags[0]}, exp_flag(k, pr, m));
      wr(4'h0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule